// File: doc/BRIEF.md
# Transmit Data Chunk Receiver

This block sits behind the byte-level serial receiver on the device side of a full-duplex host link. The host sends transmit chunks of 68 bytes. Each chunk is a 32-bit header, most significant byte first, followed by 64 payload bytes. Chunks arrive as a byte stream that is framed by a select signal. The block checks the header's parity and decodes its flags. It then passes only the payload bytes that belong to an Ethernet frame downstream, one byte per beat, with markers for the first byte, the last byte and an abandoned frame.

A frame start is given as a 32-bit word offset into the payload, and a frame end as the byte offset of the frame's last byte. The start and the end of a frame may both fall in one chunk. The end of one frame and the start of the next may also share a chunk. A frame stays open across chunks and across select transactions.

The block keeps a count of free transmit buffers. It reports an overflow when the host sends a data chunk while no buffer is free. It also flags a header with bad parity and a broken even/odd chunk sequence. It records the timestamp-capture code that the host requested for each frame.

Top module: `txchunk_rx`

## Requirements
- R1: A header with good parity and bit 31 clear is a control command. Every byte after it is ignored until `link_sel` falls: nothing is output and no credit is used.
- R2: The 32 header bits must hold an odd number of ones. Otherwise `hdr_bad` pulses for one cycle, one cycle after the fourth header byte. The following 64 bytes are discarded, no credit is used, and the next byte is taken as a new header.
- R3: A data header (bit 31 set) with good parity and bit 21 (data valid) clear produces no output and uses no credit, whatever its start and end flags say.
- R4: Bit 20 (start valid) opens a frame at payload byte 4 × bits 19:16. That byte carries `out_first`, and every later payload byte in the chunk is output.
- R5: Bit 14 (end valid) closes an open frame at payload byte bits 13:8. That byte carries `out_last`, and the bytes before it in the chunk are output. An end with no open frame outputs nothing.
- R6: When start and end fall in one chunk and the start byte is not after the end byte, the bytes from start to end form one frame, marked first and last.
- R7: When the start byte is after the end byte, the open frame ends at the end byte first. The new frame then starts at the start byte and stays open.
- R8: A start while a frame is still open continues the old frame up to the start byte. The new frame's first byte then carries `out_abort` together with `out_first`.
- R9: `credits` resets to 31. Each good data chunk with data valid set and a nonzero count takes one credit. A `buf_free` pulse returns one credit, and the count saturates at 31. A take and a return in the same cycle leave the count unchanged.
- R10: A good data chunk with data valid set that arrives when `credits` is 0 pulses `ovf_err`. Its payload is discarded and `credits` stays 0.
- R11: `out_ts` carries, on every byte of a frame, the header bits 7:6 of the chunk that started that frame. Bits 7:6 in later chunks do not change it.
- R12: `seq_err` pulses when the bit 30 of a good data header equals that of the previous good data header. The first data header after reset is never flagged.
- R13: Each output byte appears one cycle after its payload byte is taken. Dropping `link_sel` in the middle of a chunk makes the next byte a header byte. An open frame stays open across the drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_sel | input | 1 | High while a host transaction is in progress |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_byte | input | 8 | Byte from the serial receiver |
| buf_free | input | 1 | One transmit buffer was released (one-cycle pulse) |
| out_valid | output | 1 | Frame byte is valid |
| out_byte | output | 8 | Frame byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| out_abort | output | 1 | The previous frame was abandoned (set together with `out_first`) |
| out_ts | output | 2 | Timestamp-capture code of the current frame |
| credits | output | 5 | Free transmit buffer count |
| hdr_bad | output | 1 | Header parity error pulse |
| ovf_err | output | 1 | Transmit buffer overflow pulse |
| seq_err | output | 1 | Chunk sequence error pulse |

## Verification
Two situations are the hardest to reach from the ports. The first is a chunk that must close one frame and open another, with the start offset after the end offset, while a frame is already open. The bench reaches it by first opening a frame near the tail of one chunk, then sending a chunk whose end lies before its start, then closing the new frame with a third chunk. The second is the overflow path, which needs the credit count drained to zero. The bench first saturates the count with release pulses, then sends exactly 31 data chunks with data valid set, and only then sends one more. It finally raises a release pulse in the same cycle as a header's fourth byte to check that a take and a return cancel out.

// File: rtl/txc_pkg.sv
package txc_pkg;

    localparam int HDR_BYTES = 4;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_PAY,
        PH_DRAIN
    } phase_t;

    // Header layout; bit positions are decoded by the host, so they are fixed.
    typedef struct packed {
        logic       is_data;     // 31
        logic       seq;         // 30
        logic       no_rx;       // 29
        logic [4:0] pad_hi;      // 28:24
        logic [1:0] vend;        // 23:22
        logic       has_data;    // 21
        logic       has_start;   // 20
        logic [3:0] start_word;  // 19:16
        logic       pad_mid;     // 15
        logic       has_end;     // 14
        logic [5:0] end_byte;    // 13:8
        logic [1:0] ts_req;      // 7:6
        logic [4:0] pad_lo;      // 5:1
        logic       parity;      // 0
    } chunk_hdr_t;

    function automatic logic hdr_odd_ok(input logic [31:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/txc_framer.sv
module txc_framer
    import txc_pkg::*;
#(
    parameter int PAY_BYTES = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          link_sel,
    input  logic                          in_valid,
    input  logic [7:0]                    in_byte,
    output logic                          hdr_fire,
    output logic [31:0]                   hdr_word,
    output logic                          pay_valid,
    output logic [$clog2(PAY_BYTES)-1:0]  pay_pos,
    output logic [7:0]                    pay_byte
);
    localparam int POS_W = $clog2(PAY_BYTES);

    phase_t             phase_q;
    logic [POS_W-1:0]   cnt_q;
    logic [23:0]        sh_q;
    logic               take;

    assign take      = link_sel && in_valid;
    assign hdr_word  = {sh_q, in_byte};
    assign hdr_fire  = take && (phase_q == PH_HDR) && (cnt_q == POS_W'(HDR_BYTES - 1));
    assign pay_valid = take && (phase_q == PH_PAY);
    assign pay_pos   = cnt_q;
    assign pay_byte  = in_byte;

    always_ff @(posedge clk) begin
        if (rst || !link_sel) begin
            phase_q <= PH_HDR;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else if (take) begin
            case (phase_q)
                PH_HDR: begin
                    sh_q <= {sh_q[15:0], in_byte};
                    if (hdr_fire) begin
                        cnt_q   <= '0;
                        phase_q <= (hdr_odd_ok(hdr_word) && !hdr_word[31]) ? PH_DRAIN : PH_PAY;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PAY: begin
                    if (cnt_q == POS_W'(PAY_BYTES - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_HDR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_DRAIN;
                end
            endcase
        end
    end

endmodule

// File: rtl/txc_credit.sv
module txc_credit #(
    parameter int CREDIT_MAX = 31
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              consume,
    input  logic                              release_one,
    output logic [$clog2(CREDIT_MAX+1)-1:0]   level,
    output logic                              empty
);
    localparam int CW = $clog2(CREDIT_MAX + 1);

    logic [CW-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= CW'(CREDIT_MAX);
        end else if (consume && !release_one) begin
            lvl_q <= lvl_q - 1'b1;
        end else if (release_one && !consume && (lvl_q != CW'(CREDIT_MAX))) begin
            lvl_q <= lvl_q + 1'b1;
        end
    end

    assign level = lvl_q;
    assign empty = (lvl_q == '0);

endmodule

// File: rtl/txc_extract.sv
module txc_extract
    import txc_pkg::*;
#(
    parameter int PAY_BYTES = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          byte_vld,
    input  logic [$clog2(PAY_BYTES)-1:0]  pos,
    input  logic [7:0]                    byte_in,
    input  chunk_hdr_t                    hdr,
    output logic                          out_valid,
    output logic [7:0]                    out_byte,
    output logic                          out_first,
    output logic                          out_last,
    output logic                          out_abort,
    output logic [1:0]                    out_ts
);
    localparam int POS_W = $clog2(PAY_BYTES);

    logic               open_q;
    logic [1:0]         ts_q;
    logic [POS_W-1:0]   s_pos;
    logic [POS_W-1:0]   e_pos;
    logic               start_here;
    logic               emit;
    logic               last;
    logic [1:0]         ts_now;

    assign s_pos      = POS_W'({hdr.start_word, 2'b00});
    assign e_pos      = POS_W'(hdr.end_byte);
    assign start_here = byte_vld && hdr.has_start && (pos == s_pos);
    assign emit       = byte_vld && (open_q || start_here);
    assign last       = emit && hdr.has_end && (pos == e_pos);
    assign ts_now     = start_here ? hdr.ts_req : ts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            ts_q      <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_abort <= 1'b0;
            out_ts    <= '0;
        end else begin
            out_valid <= emit;
            out_byte  <= byte_in;
            out_first <= start_here;
            out_last  <= last;
            out_abort <= start_here && open_q;
            out_ts    <= ts_now;
            if (byte_vld) begin
                open_q <= emit && !last;
            end
            if (start_here) begin
                ts_q <= hdr.ts_req;
            end
        end
    end

endmodule

// File: rtl/txchunk_rx.sv
module txchunk_rx
    import txc_pkg::*;
#(
    parameter int PAY_BYTES  = 64,
    parameter int CREDIT_MAX = 31
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              link_sel,
    input  logic                              in_valid,
    input  logic [7:0]                        in_byte,
    input  logic                              buf_free,
    output logic                              out_valid,
    output logic [7:0]                        out_byte,
    output logic                              out_first,
    output logic                              out_last,
    output logic                              out_abort,
    output logic [1:0]                        out_ts,
    output logic [$clog2(CREDIT_MAX+1)-1:0]   credits,
    output logic                              hdr_bad,
    output logic                              ovf_err,
    output logic                              seq_err
);
    localparam int POS_W = $clog2(PAY_BYTES);

    logic               hdr_fire;
    logic [31:0]        hdr_word;
    logic               pay_valid;
    logic [POS_W-1:0]   pay_pos;
    logic [7:0]         pay_byte;

    chunk_hdr_t         hw;
    chunk_hdr_t         hdr_q;
    logic               par_ok;
    logic               good_data;
    logic               want;
    logic               no_credit;
    logic               consume;
    logic               take_q;
    logic               seen_q;
    logic               seq_q;

    txc_framer #(.PAY_BYTES(PAY_BYTES)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .link_sel  (link_sel),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .hdr_fire  (hdr_fire),
        .hdr_word  (hdr_word),
        .pay_valid (pay_valid),
        .pay_pos   (pay_pos),
        .pay_byte  (pay_byte)
    );

    assign hw        = chunk_hdr_t'(hdr_word);
    assign par_ok    = hdr_odd_ok(hdr_word);
    assign good_data = hdr_fire && par_ok && hw.is_data;
    assign want      = good_data && hw.has_data;
    assign consume   = want && !no_credit;

    txc_credit #(.CREDIT_MAX(CREDIT_MAX)) u_credit (
        .clk         (clk),
        .rst         (rst),
        .consume     (consume),
        .release_one (buf_free),
        .level       (credits),
        .empty       (no_credit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q  <= 1'b0;
            hdr_q   <= '0;
            hdr_bad <= 1'b0;
            ovf_err <= 1'b0;
            seq_err <= 1'b0;
            seen_q  <= 1'b0;
            seq_q   <= 1'b0;
        end else begin
            hdr_bad <= hdr_fire && !par_ok;
            ovf_err <= want && no_credit;
            seq_err <= good_data && seen_q && (hw.seq == seq_q);
            if (hdr_fire) begin
                take_q <= consume;
                hdr_q  <= hw;
            end
            if (good_data) begin
                seen_q <= 1'b1;
                seq_q  <= hw.seq;
            end
        end
    end

    txc_extract #(.PAY_BYTES(PAY_BYTES)) u_extract (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (pay_valid && take_q),
        .pos       (pay_pos),
        .byte_in   (pay_byte),
        .hdr       (hdr_q),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_first (out_first),
        .out_last  (out_last),
        .out_abort (out_abort),
        .out_ts    (out_ts)
    );

endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
    parameter int CREDIT_MAX = 31
) (
    input logic                              clk,
    input logic                              rst,
    input logic [$clog2(CREDIT_MAX+1)-1:0]   credits,
    input logic                              out_valid,
    input logic                              out_first,
    input logic                              out_last,
    input logic                              out_abort,
    input logic                              hdr_bad,
    input logic                              ovf_err
);
    p_credit_cap_r9: assert property (@(posedge clk) disable iff (rst)
        int'(credits) <= CREDIT_MAX);

    p_credit_step_r9: assert property (@(posedge clk) disable iff (rst)
        (credits != $past(credits)) |->
            ((int'(credits) == int'($past(credits)) + 1) ||
             (int'(credits) == int'($past(credits)) - 1)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        ovf_err |-> ($past(credits) == '0));

    p_first_valid_r4: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);

    p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    p_abort_first_r8: assert property (@(posedge clk) disable iff (rst)
        out_abort |-> out_first);

    p_bad_no_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        hdr_bad |-> !ovf_err);

endmodule

bind txchunk_rx txc_checker #(.CREDIT_MAX(CREDIT_MAX)) i_txc_checker (
    .clk       (clk),
    .rst       (rst),
    .credits   (credits),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_last  (out_last),
    .out_abort (out_abort),
    .hdr_bad   (hdr_bad),
    .ovf_err   (ovf_err)
);

// File: tb/test_txchunk_rx.sv
`timescale 1ns/1ps
module test_txchunk_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_sel = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       buf_free = 1'b0;
    logic       out_valid, out_first, out_last, out_abort;
    logic [7:0] out_byte;
    logic [1:0] out_ts;
    logic [4:0] credits;
    logic       hdr_bad, ovf_err, seq_err;

    always #10 clk = ~clk;

    txchunk_rx i_txchunk_rx (
        .clk(clk), .rst(rst), .link_sel(link_sel), .in_valid(in_valid),
        .in_byte(in_byte), .buf_free(buf_free), .out_valid(out_valid),
        .out_byte(out_byte), .out_first(out_first), .out_last(out_last),
        .out_abort(out_abort), .out_ts(out_ts), .credits(credits),
        .hdr_bad(hdr_bad), .ovf_err(ovf_err), .seq_err(seq_err)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    bit done = 0;
    int on = 0, n_bad = 0, n_ovf = 0, n_seq = 0;
    int ob [0:1023];
    int of [0:1023];
    int ol [0:1023];
    int oa [0:1023];
    int ot [0:1023];
    int oc [0:1023];
    int pcyc [0:63];
    int exp_cred = 31;
    int exp_ovf = 0;
    bit nseq = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid && on < 1024) begin
            ob[on] = out_byte; of[on] = out_first; ol[on] = out_last;
            oa[on] = out_abort; ot[on] = out_ts; oc[on] = cyc;
            on++;
        end
        if (hdr_bad) n_bad++;
        if (ovf_err) n_ovf++;
        if (seq_err) n_seq++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        @(posedge clk);
        on = 0; n_bad = 0; n_ovf = 0; n_seq = 0;
    endtask

    function automatic logic [31:0] mk(bit sq, bit dv, bit sv, int swo, bit ev, int ebo, int ts);
        logic [31:0] w;
        w = {1'b1, sq, 1'b0, 5'b0, 2'b0, dv, sv, 4'(swo), 1'b0, ev, 6'(ebo), 2'(ts), 5'b0, 1'b0};
        w[0] = ~(^w[31:1]);
        return w;
    endfunction

    task automatic put(input logic [7:0] b, input bit fr);
        @(negedge clk);
        link_sel = 1'b1; in_valid = 1'b1; in_byte = b; buf_free = fr;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; buf_free = 1'b0;
        end
    endtask

    task automatic sel_off();
        @(negedge clk);
        in_valid = 1'b0; buf_free = 1'b0; link_sel = 1'b0;
        @(negedge clk);
        link_sel = 1'b1;
    endtask

    task automatic raw_chunk(input logic [31:0] h, input int base, input bit fr);
        for (int i = 0; i < 4; i++) put(h[31-8*i -: 8], fr && (i == 3));
        for (int p = 0; p < 64; p++) begin
            put(8'((base + p) & 255), 1'b0);
            pcyc[p] = cyc;
        end
    endtask

    task automatic chunk(input logic [31:0] h, input int base, input bit fr);
        bit used;
        used = 0;
        raw_chunk(h, base, fr);
        if ((^h) && h[31] && h[21]) begin
            if (exp_cred == 0) exp_ovf++;
            else used = 1;
        end
        if ((^h) && h[31]) nseq = ~h[30];
        if (used && !fr) exp_cred--;
        else if (!used && fr && exp_cred < 31) exp_cred++;
    endtask

    task automatic chk_run(input string tag, input int idx, input int p0, input int p1,
                           input int base, input bit f, input bit l, input int ts);
        int bad;
        bad = 0;
        for (int p = p0; p <= p1; p++) begin
            int k;
            k = idx + p - p0;
            if (ob[k] != ((base + p) & 255)) bad++;
            if (of[k] != int'(f && p == p0)) bad++;
            if (ol[k] != int'(l && p == p1)) bad++;
            if (ot[k] != ts) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        chk(credits == 5'd31, "R9 reset credits", credits, 31);
        chk(!out_valid && !hdr_bad && !ovf_err && !seq_err, "R9 reset outputs idle",
            int'({out_valid, hdr_bad, ovf_err, seq_err}), 0);
    endtask

    task automatic t_single();
        clr();
        chunk(mk(nseq, 1, 1, 2, 1, 20, 2), 8'h30, 0);
        idle(3);
        chk(on == 13, "R6 single-chunk frame length", on, 13);
        chk_run("R6 R4 R5 R11 single-chunk bytes", 0, 8, 20, 8'h30, 1, 1, 2);
        chk(oc[0] == pcyc[8] + 1, "R13 output latency", oc[0] - pcyc[8], 1);
        chk(credits == exp_cred, "R9 credit taken", credits, exp_cred);
    endtask

    task automatic t_span();
        clr();
        chunk(mk(nseq, 1, 1, 15, 0, 0, 1), 8'h00, 0);
        chunk(mk(nseq, 1, 0, 0, 0, 0, 3), 8'h50, 0);
        chunk(mk(nseq, 1, 0, 0, 1, 3, 2), 8'hA0, 0);
        idle(3);
        chk(on == 72, "R4 R5 spanning frame length", on, 72);
        chk_run("R4 span head", 0, 60, 63, 8'h00, 1, 0, 1);
        chk_run("R11 span middle keeps ts", 4, 0, 63, 8'h50, 0, 0, 1);
        chk_run("R5 span tail", 68, 0, 3, 8'hA0, 0, 1, 1);
        chk(n_seq == 0, "R12 toggling sequence", n_seq, 0);
        chk(credits == exp_cred, "R9 three credits taken", credits, exp_cred);
    endtask

    task automatic t_seq();
        clr();
        chunk(mk(nseq, 0, 0, 0, 0, 0, 0), 0, 0);
        chunk(mk(~nseq, 0, 0, 0, 0, 0, 0), 0, 0);
        idle(3);
        chk(n_seq == 1, "R12 repeated sequence flagged", n_seq, 1);
        clr();
        chunk(mk(nseq, 0, 0, 0, 0, 0, 0), 0, 0);
        idle(3);
        chk(n_seq == 0, "R12 recovered sequence", n_seq, 0);
    endtask

    task automatic t_dv0();
        int c0;
        clr();
        c0 = credits;
        chunk(mk(nseq, 0, 1, 0, 1, 10, 1), 8'h11, 0);
        idle(3);
        chk(on == 0, "R3 no-data chunk outputs nothing", on, 0);
        chk(credits == c0, "R3 no-data chunk keeps credits", credits, c0);
    endtask

    task automatic t_split();
        int na;
        clr();
        chunk(mk(nseq, 1, 1, 10, 0, 0, 0), 8'h10, 0);
        chunk(mk(nseq, 1, 1, 8, 1, 5, 0), 8'h40, 0);
        chunk(mk(nseq, 1, 0, 0, 1, 0, 0), 8'h90, 0);
        idle(3);
        na = 0;
        for (int i = 0; i < on; i++) na += oa[i];
        chk(on == 63, "R7 split chunk total bytes", on, 63);
        chk_run("R7 first frame head", 0, 40, 63, 8'h10, 1, 0, 0);
        chk_run("R7 old frame ends first", 24, 0, 5, 8'h40, 0, 1, 0);
        chk_run("R7 new frame starts after", 30, 32, 63, 8'h40, 1, 0, 0);
        chk_run("R7 new frame closes", 62, 0, 0, 8'h90, 0, 1, 0);
        chk(na == 0, "R7 no abort on end-then-start", na, 0);
    endtask

    task automatic t_abort();
        int na;
        clr();
        chunk(mk(nseq, 1, 1, 12, 0, 0, 3), 8'h20, 0);
        chunk(mk(nseq, 1, 1, 4, 0, 0, 1), 8'h60, 0);
        chunk(mk(nseq, 1, 0, 0, 1, 63, 0), 8'hC0, 0);
        idle(3);
        na = 0;
        for (int i = 0; i < on; i++) na += oa[i];
        chk(on == 144, "R8 abort scenario byte count", on, 144);
        chk_run("R8 old frame head", 0, 48, 63, 8'h20, 1, 0, 3);
        chk_run("R8 old frame continues to start", 16, 0, 15, 8'h60, 0, 0, 3);
        chk_run("R11 new frame ts", 32, 16, 63, 8'h60, 1, 0, 1);
        chk_run("R8 new frame closes", 80, 0, 63, 8'hC0, 0, 1, 1);
        chk(na == 1 && oa[32] == 1, "R8 abort on new first byte", na, 1);
    endtask

    task automatic t_parity();
        int c0;
        clr();
        c0 = credits;
        chunk(mk(nseq, 1, 1, 0, 1, 7, 0) ^ 32'h1, 8'h33, 0);
        idle(3);
        chk(n_bad == 1, "R2 bad parity flagged", n_bad, 1);
        chk(on == 0, "R2 bad chunk discarded", on, 0);
        chk(credits == c0, "R2 bad chunk keeps credits", credits, c0);
        clr();
        chunk(mk(nseq, 1, 1, 0, 1, 0, 0), 8'h44, 0);
        idle(3);
        chk(on == 1 && ob[0] == 8'h44 && of[0] == 1 && ol[0] == 1,
            "R2 realigned after bad header", on, 1);
    endtask

    task automatic t_ctrl();
        logic [31:0] c;
        int c0;
        clr();
        c0 = credits;
        c = 32'h2000_0200;
        c[0] = ~(^c[31:1]);
        for (int i = 0; i < 4; i++) put(c[31-8*i -: 8], 1'b0);
        raw_chunk(mk(nseq, 1, 1, 0, 1, 3, 0), 8'h55, 0);
        idle(3);
        chk(on == 0, "R1 control transaction ignored", on, 0);
        chk(credits == c0 && n_bad == 0, "R1 control keeps credits", credits, c0);
        sel_off();
        clr();
        chunk(mk(nseq, 1, 1, 0, 1, 3, 0), 8'h66, 0);
        idle(3);
        chk(on == 4, "R1 data after select drop", on, 4);
    endtask

    task automatic t_seldrop();
        logic [31:0] h;
        clr();
        h = mk(nseq, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) put(h[31-8*i -: 8], 1'b0);
        for (int p = 0; p < 10; p++) put(8'((8'h70 + p) & 255), 1'b0);
        exp_cred--; nseq = ~nseq;
        sel_off();
        chunk(mk(nseq, 1, 0, 0, 1, 1, 0), 8'hE0, 0);
        idle(3);
        chk(on == 12, "R13 frame kept across select drop", on, 12);
        chk_run("R13 partial chunk bytes", 0, 0, 9, 8'h70, 1, 0, 0);
        chk_run("R13 realigned header after drop", 10, 0, 1, 8'hE0, 0, 1, 0);
        chk(credits == exp_cred, "R9 credits after drop", credits, exp_cred);
    endtask

    task automatic t_credit();
        repeat (40) begin
            @(negedge clk); in_valid = 1'b0; buf_free = 1'b1;
            @(negedge clk); buf_free = 1'b0;
            if (exp_cred < 31) exp_cred++;
        end
        chk(credits == 5'd31, "R9 saturate at 31", credits, 31);
        clr();
        repeat (31) chunk(mk(nseq, 1, 0, 0, 0, 0, 0), 0, 0);
        idle(3);
        chk(credits == 0 && n_ovf == 0, "R9 drained to zero", credits, 0);
        clr();
        chunk(mk(nseq, 1, 1, 0, 1, 3, 0), 8'h12, 0);
        idle(3);
        chk(n_ovf == 1, "R10 overflow flagged", n_ovf, 1);
        chk(on == 0 && credits == 0, "R10 overflow chunk discarded", on, 0);
        @(negedge clk); buf_free = 1'b1;
        @(negedge clk); buf_free = 1'b0;
        exp_cred = 1;
        chunk(mk(nseq, 1, 0, 0, 0, 0, 0), 0, 1);
        idle(3);
        chk(credits == 1, "R9 take and return cancel", credits, 1);
        chk(credits == exp_cred, "R9 model agrees", credits, exp_cred);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        link_sel = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_span();
        t_seq();
        t_dv0();
        t_split();
        t_abort();
        t_parity();
        t_ctrl();
        t_seldrop();
        t_credit();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule